// File: doc/BRIEF.md
# Guest Bus Post Office Bridge

This bridge lets host software reach byte-wide registers in up to eight small peripheral devices that hang off a narrow parallel guest bus. Software issues a whole transaction with one 32-bit write to a single command/status word. That word carries the direction, which guest to select, the 3-bit register index inside that guest and, for a write, the data byte. The bridge then selects the guest, holds a setup interval, pulses the read or write strobe, and waits for the guest to acknowledge. While the transfer runs, a pending bit in the same word reads as 1. Software polls that bit to learn when the transfer is done. After a read, the returned byte sits in the low byte of the word.

Each guest has its own 4-bit timing value in a separate configuration word. That value sets both the setup interval and the minimum strobe width. If a command enables the timeout, a guest that never acknowledges ends the transfer after a fixed wait and sets a timeout flag, so the bridge does not hang. Some boards leave the acknowledge line unconnected. On those boards every transfer ends this way, and software must treat the flag as informational.

Top module: `guest_po_bridge`

## Requirements
- R1: After reset, the status word reads 0, no chip select is active, both strobes are low and the data output enable is low. All per-guest timing values reset to 0.
- R2: A command's guest field (bits 22:20) selects exactly one chip select line, `gb_cs[guest]`. Its register field (bits 18:16) appears on `gb_addr`. Both are held for the whole transfer, and both fields read back at the same positions.
- R3: Command bit 24 set means write: `gb_wr` strobes, and `gb_doe` is high with `gb_dout` equal to command bits 7:0 while the guest is selected. Bit 24 clear means read: `gb_rd` strobes and `gb_doe` stays low.
- R4: Status bit 31 (pending) reads 1 from the cycle after a command is accepted until the transfer ends. A command is accepted when `host_wr` is high while pending is 0.
- R5: When a read is acknowledged, the value on `gb_din` in the acknowledge cycle appears in status bits 7:0.
- R6: For a guest with timing value T, stored in `cfg_wdata[4g+3:4g]`, the guest is selected with both strobes low for T+1 cycles. The strobe is then high for at least T+1 cycles. With the acknowledge already high, the strobe lasts exactly T+1 cycles and pending stays set for 2T+2 cycles.
- R7: If timeout enable (command bit 25) is set and no acknowledge arrives, the bridge waits 64 cycles after the minimum strobe width, then ends the transfer and sets status bit 30. Pending lasts 2T+65 cycles, and a timed-out read leaves bits 7:0 at the command's data byte. The flag clears when the next command is accepted.
- R8: With timeout enable clear, the bridge waits for the acknowledge without limit, and the timeout flag stays 0.
- R9: A command written while pending is 1 has no effect. The running transfer finishes with its original guest, register, direction and data.
- R10: At most one chip select is active. The read and write strobes are never high together, and neither is high without a chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the command word |
| host_wdata | input | 32 | Command word |
| host_rdata | output | 32 | Status word: pending, timeout, echoed fields, data byte |
| cfg_wr | input | 1 | Write strobe for the timing configuration word |
| cfg_wdata | input | 32 | Per-guest 4-bit timing values, guest g at bits 4g+3:4g |
| gb_cs | output | 8 | One-hot guest chip selects, active high |
| gb_addr | output | 3 | Guest register index |
| gb_rd | output | 1 | Read strobe, active high |
| gb_wr | output | 1 | Write strobe, active high |
| gb_dout | output | 8 | Data driven to the guest |
| gb_doe | output | 1 | Output enable for `gb_dout` |
| gb_din | input | 8 | Data returned by the guest |
| gb_ack | input | 1 | Guest acknowledge, active high |

## Verification
Some properties are checked by assertions on every cycle. These are the one-hot chip select and the mutually exclusive strobes, and that no read strobe occurs while the data bus is driven. The assertions also cover the address, which stays put for the whole transfer, and the pending bit, which rises on an accepted command. They also check that a command arriving while pending leaves the echoed fields alone, and that the timeout flag rises only as pending falls. The exact setup and strobe lengths for each guest's timing value, the returned read byte, the captured write byte, the 64-cycle timeout and the unbounded wait when the timeout is disabled depend on the guest's response. The bench's scenarios show those.

// File: rtl/guest_po_bridge.sv
module guest_po_bridge #(
  parameter int TIME_W     = 4,
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              cfg_wr,
  input  logic [8*TIME_W-1:0] cfg_wdata,
  output logic [7:0]        gb_cs,
  output logic [2:0]        gb_addr,
  output logic              gb_rd,
  output logic              gb_wr,
  output logic [7:0]        gb_dout,
  output logic              gb_doe,
  input  logic [7:0]        gb_din,
  input  logic              gb_ack
);
  localparam int NG    = 8;
  localparam int TMO_W = $clog2(TMO_CYCLES);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB} st_t;

  st_t               st;
  logic [TIME_W-1:0] tcfg [NG];
  logic [TIME_W-1:0] cnt;
  logic [TMO_W-1:0]  tcnt;
  logic              dir_q, ten_q, tmo_q;
  logic [2:0]        gsel_q, reg_q;
  logic [7:0]        data_q;
  logic              pend;

  assign pend = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tcnt   <= '0;
      dir_q  <= 1'b0;
      ten_q  <= 1'b0;
      tmo_q  <= 1'b0;
      gsel_q <= '0;
      reg_q  <= '0;
      data_q <= '0;
      for (int i = 0; i < NG; i++) tcfg[i] <= '0;
    end else begin
      if (cfg_wr)
        for (int i = 0; i < NG; i++) tcfg[i] <= cfg_wdata[i*TIME_W +: TIME_W];
      case (st)
        S_IDLE: if (host_wr) begin
          dir_q  <= host_wdata[24];
          ten_q  <= host_wdata[25];
          gsel_q <= host_wdata[22:20];
          reg_q  <= host_wdata[18:16];
          data_q <= host_wdata[7:0];
          tmo_q  <= 1'b0;
          cnt    <= tcfg[host_wdata[22:20]];
          st     <= S_SETUP;
        end
        S_SETUP: if (cnt == '0) begin
          cnt  <= tcfg[gsel_q];
          tcnt <= '0;
          st   <= S_STRB;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_STRB: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (gb_ack) begin
          if (!dir_q) data_q <= gb_din;
          st <= S_IDLE;
        end else if (ten_q && tcnt == TMO_W'(TMO_CYCLES - 1)) begin
          tmo_q <= 1'b1;
          st    <= S_IDLE;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign gb_cs      = pend ? (NG'(1) << gsel_q) : '0;
  assign gb_addr    = pend ? reg_q : '0;
  assign gb_rd      = (st == S_STRB) && !dir_q;
  assign gb_wr      = (st == S_STRB) && dir_q;
  assign gb_doe     = pend && dir_q;
  assign gb_dout    = gb_doe ? data_q : '0;
  assign host_rdata = {pend, tmo_q, 4'b0000, ten_q, dir_q, 1'b0, gsel_q,
                       1'b0, reg_q, 8'h00, data_q};
endmodule

// File: rtl/guest_po_bridge_chk.sv
module guest_po_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [31:0] status,
  input logic [7:0]  gb_cs,
  input logic [2:0]  gb_addr,
  input logic        gb_rd,
  input logic        gb_wr,
  input logic        gb_doe
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gb_cs)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gb_rd && gb_wr)); // R10
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (gb_rd || gb_wr) |-> (gb_cs != 8'h00)); // R10
  AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    gb_rd |-> !gb_doe); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((gb_cs != 8'h00) && ($past(gb_cs) != 8'h00)) |-> $stable(gb_addr)); // R2
  AST_ACCEPT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[31] && host_wr) |=> status[31]); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31] && host_wr) |=> $stable(status[25:16])); // R9
  AST_TMO_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[30]) |-> $fell(status[31])); // R7
  AST_TMO_CLEAR_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[30]) |-> $rose(status[31])); // R7
endmodule

bind guest_po_bridge guest_po_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .status(host_rdata),
  .gb_cs(gb_cs), .gb_addr(gb_addr), .gb_rd(gb_rd), .gb_wr(gb_wr),
  .gb_doe(gb_doe)
);

// File: tb/tb_guest_po_bridge.sv
`timescale 1ns/1ps
module tb_guest_po_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  gb_cs;
  logic [2:0]  gb_addr;
  logic        gb_rd, gb_wr, gb_doe;
  logic [7:0]  gb_dout;
  logic [7:0]  gb_din;
  logic        gb_ack;

  logic [7:0]  ack_mask = 8'hBF;
  logic [7:0]  cap_data = '0;
  int          cap_cnt = 0;
  int          checks = 0;
  int          fails = 0;

  localparam logic [31:0] CFG = 32'h4752F310;
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 3'd0, 3'd0, 8'h3C},
    {1'b0, 3'd0, 3'd5, 8'h00},
    {1'b1, 3'd1, 3'd7, 8'hFF},
    {1'b0, 3'd2, 3'd2, 8'h11},
    {1'b1, 3'd3, 3'd1, 8'h00},
    {1'b0, 3'd4, 3'd6, 8'h99},
    {1'b0, 3'd6, 3'd3, 8'h77},
    {1'b1, 3'd7, 3'd4, 8'h81},
    {1'b1, 3'd6, 3'd0, 8'h12},
    {1'b0, 3'd5, 3'd7, 8'h00}
  };

  always #2.5 clk = ~clk;

  guest_po_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .gb_cs(gb_cs), .gb_addr(gb_addr), .gb_rd(gb_rd), .gb_wr(gb_wr),
    .gb_dout(gb_dout), .gb_doe(gb_doe), .gb_din(gb_din), .gb_ack(gb_ack)
  );

  function automatic logic [7:0] rdval(input logic [2:0] g, input logic [2:0] r);
    return {g, r, 2'b01} ^ 8'hA5;
  endfunction

  function automatic int t_of(input logic [2:0] g);
    return int'(CFG[g*4 +: 4]);
  endfunction

  logic [2:0] cur_g;
  always_comb begin
    cur_g = 3'd0;
    for (int i = 0; i < 8; i++) if (gb_cs[i]) cur_g = 3'(i);
  end

  assign gb_ack = (gb_rd || gb_wr) && ((ack_mask & gb_cs) != 8'h00);
  assign gb_din = gb_rd ? rdval(cur_g, gb_addr) : 8'h00;

  always @(posedge clk) if (gb_wr && gb_ack) begin
    cap_data <= gb_dout;
    cap_cnt  <= cap_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic watch(input logic dir, input logic [2:0] g, input logic [2:0] r,
                       input logic [7:0] d, output int busy, output int setup,
                       output int strb, output int bad_sel, output int bad_dir);
    busy = 0; setup = 0; strb = 0; bad_sel = 0; bad_dir = 0;
    while (host_rdata[31] && busy < 3000) begin
      if (gb_cs !== (8'h01 << g) || gb_addr !== r) bad_sel++;
      if (gb_rd || gb_wr) begin
        strb++;
        if (gb_rd === dir || gb_wr !== dir) bad_dir++;
      end else setup++;
      if (dir && (!gb_doe || gb_dout !== d)) bad_dir++;
      if (!dir && gb_doe) bad_dir++;
      busy++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int busy, setup, strb, bad_sel, bad_dir, cc, t;
    logic dir, tmo;
    logic [2:0] g, r;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    check("R1 status", host_rdata, 32'h0);
    check("R1 bus idle", {gb_cs, gb_rd, gb_wr, gb_doe}, 11'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after release", host_rdata, 32'h0);

    cfg_wr = 1'b1;
    cfg_wdata = CFG;
    @(negedge clk);
    cfg_wr = 1'b0;

    for (int v = 0; v < NV; v++) begin
      {dir, g, r, d} = VEC[v];
      t = t_of(g);
      tmo = !ack_mask[g];
      cc = cap_cnt;
      start_cmd({6'b0, 1'b1, dir, 1'b0, g, 1'b0, r, 8'h00, d});
      watch(dir, g, r, d, busy, setup, strb, bad_sel, bad_dir);
      check("R2 select and address", 32'(bad_sel), 32'h0);
      check("R3 direction and drive", 32'(bad_dir), 32'h0);
      check("R6 setup length", 32'(setup), 32'(t + 1));
      check("R4 pending length", 32'(busy), tmo ? 32'(2*t + 65) : 32'(2*t + 2));
      if (tmo) check("R7 strobe until timeout", 32'(strb), 32'(t + 64));
      else     check("R6 strobe width", 32'(strb), 32'(t + 1));
      check("R7 timeout flag (cleared by new command)", {31'b0, host_rdata[30]}, {31'b0, tmo});
      check("R2 fields echoed", {16'b0, host_rdata[25:16]}, {16'b0, 1'b1, dir, 1'b0, g, 1'b0, r});
      if (!dir) check(tmo ? "R7 data kept on timeout" : "R5 read data",
                      {24'b0, host_rdata[7:0]}, {24'b0, tmo ? d : rdval(g, r)});
      else if (!tmo) check("R3 write byte captured", {24'b0, cap_data}, {24'b0, d});
      else check("R7 no write on timeout", 32'(cap_cnt), 32'(cc));
    end

    // R9: second command while pending is ignored
    cc = cap_cnt;
    start_cmd({6'b0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 3'd2, 8'h00, 8'h00});
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = {6'b0, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 3'd5, 8'h00, 8'hEE};
    @(negedge clk);
    host_wr = 1'b0;
    watch(1'b0, 3'd3, 3'd2, 8'h00, busy, setup, strb, bad_sel, bad_dir);
    check("R9 bus unchanged", 32'(bad_sel + bad_dir), 32'h0);
    check("R9 fields kept", {16'b0, host_rdata[25:16]}, {16'b0, 10'b1000110010});
    check("R9 original read data", {24'b0, host_rdata[7:0]}, {24'b0, rdval(3'd3, 3'd2)});
    check("R9 no write issued", 32'(cap_cnt), 32'(cc));
    check("R9 total pending length", 32'(busy + 2), 32'(2*15 + 2));

    // R8: timeout disabled waits for a late acknowledge
    start_cmd({6'b0, 1'b0, 1'b0, 1'b0, 3'd6, 1'b0, 3'd1, 8'h00, 8'h00});
    repeat (150) @(negedge clk);
    check("R8 still pending", {31'b0, host_rdata[31]}, 32'h1);
    check("R8 no timeout flag", {31'b0, host_rdata[30]}, 32'h0);
    ack_mask = 8'hFF;
    busy = 0;
    while (host_rdata[31] && busy < 100) begin busy++; @(negedge clk); end
    check("R8 completes on acknowledge", {31'b0, host_rdata[31]}, 32'h0);
    check("R8 late read data", {24'b0, host_rdata[7:0]}, {24'b0, rdval(3'd6, 3'd1)});
    check("R8 flag stays clear", {31'b0, host_rdata[30]}, 32'h0);
    check("R10 bus idle after transfer", {gb_cs, gb_rd, gb_wr, gb_doe}, 11'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule